// File: doc/BRIEF.md
# Thirteen-Input Majority Voter

This block reports whether a 13-bit word holds a majority of ones. The result is 1 when seven or more of the input bits are 1, and 0 otherwise. It is meant for a datapath that has to make this decision within a single short clock period, such as a 20 ns cycle. For that reason the population count is not built as a loop of accumulating adders.

Twelve of the inputs are split into four three-bit groups. A small lookup turns each group straight into a count from 0 to 3. Two adders then combine the groups in pairs, giving two partial sums of 0 to 6 each. One final add gives the total of those twelve bits. The thirteenth bit never enters that sum. Instead it picks the threshold for the final compare: six ones are enough when the top bit is set, and seven are needed when it is clear.

A parameter chooses between a purely combinational result and a result registered on the rising clock edge. The registered form has an asynchronous active-low reset. The reset is applied at once and released in step with the clock.

Top module: `maj13_voter`

## Requirements
- R1: The input `bits_in` is 13 bits wide. The output `vote_out` is the majority of the word: 1 exactly when the number of ones in `bits_in` is at least 7, and 0 otherwise.
- R2: The low twelve bits form four groups of three: bits [2:0], [5:3], [8:6] and [11:9]. Each group is decoded into a 2-bit count equal to the number of ones in that group (0 to 3).
- R3: The groups are added in pairs, [2:0] with [5:3] and [8:6] with [11:9]. This gives two 3-bit partial sums, each equal to the sum of its two group counts and never above 6.
- R4: Bit 12 is never added into the count. When bit 12 is 1, the result is 1 exactly when at least 6 of bits [11:0] are set. When bit 12 is 0, at least 7 of bits [11:0] must be set.
- R5: The two partial sums add to a 4-bit total in the range 0 to 12, equal to the number of ones in bits [11:0]. The total is compared against the selected threshold with a greater-or-equal compare.
- R6: With `REG_OUT` = 1 (the default), the result for the input present at a rising edge of `clk` appears on `vote_out` just after that edge and holds until the next edge. With `REG_OUT` = 0, `vote_out` follows `bits_in` with no clock.
- R7: With `REG_OUT` = 1, driving `rst_n` low forces `vote_out` to 0 at once, whatever the input. The output stays 0 through the first rising edge after `rst_n` returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the output register (unused when `REG_OUT` = 0) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bits_in | input | 13 | Word to be voted on |
| vote_out | output | 1 | Majority result, 1 when seven or more input bits are 1 |

## Verification
On every cycle out of reset, the assertions check each group count, both partial sums and the twelve-bit total against direct bit counts of the live input. They also check the threshold choice made by bit 12 and the final majority against a thirteen-bit count. Two further assertions cover the output register: that it carries the previous cycle's result, and that it reads 0 whenever the synchronised reset is low. The bench scenarios add what only the ports can show. It sweeps all 8192 words through the register with one-cycle latency, checks that the output still holds its old value just before the capturing edge, and checks that a reset in mid-stream clears a result of 1 and keeps it clear through the first edge after release.

// File: rtl/maj_pkg.sv
package maj_pkg;
  localparam int IN_W     = 13;
  localparam int GRP_W    = 3;
  localparam int N_GRP    = (IN_W - 1) / GRP_W;
  localparam int N_PAIR   = N_GRP / 2;
  localparam int CNT_W    = $clog2(GRP_W + 1);
  localparam int PAIR_W   = $clog2(2 * GRP_W + 1);
  localparam int TOT_MAX  = IN_W - 1;
  localparam int TOT_W    = $clog2(TOT_MAX + 1);
  localparam int NEED     = IN_W / 2 + 1;
  localparam int NEED_TOP = NEED - 1;

  typedef logic [CNT_W-1:0]  grp_cnt_t;
  typedef logic [PAIR_W-1:0] pair_sum_t;
  typedef logic [TOT_W-1:0]  total_t;
endpackage

// File: rtl/maj_trio_count.sv
module maj_trio_count
  import maj_pkg::*;
(
  input  logic [GRP_W-1:0] trio,
  output grp_cnt_t         cnt
);
  // Direct decode of three bits into their population count.
  always_comb begin
    unique case (trio)
      3'b000:                         cnt = 2'd0;
      3'b001, 3'b010, 3'b100:         cnt = 2'd1;
      3'b011, 3'b101, 3'b110:         cnt = 2'd2;
      default:                        cnt = 2'd3;
    endcase
  end
endmodule

// File: rtl/maj_pair_add.sv
module maj_pair_add
  import maj_pkg::*;
(
  input  grp_cnt_t  cnt_a,
  input  grp_cnt_t  cnt_b,
  output pair_sum_t psum
);
  always_comb begin
    psum = PAIR_W'(cnt_a) + PAIR_W'(cnt_b);
  end
endmodule

// File: rtl/maj_decide.sv
module maj_decide
  import maj_pkg::*;
(
  input  pair_sum_t psum_lo,
  input  pair_sum_t psum_hi,
  input  logic      top_bit,
  output total_t    total,
  output logic      vote
);
  total_t thresh;

  always_comb begin
    total  = TOT_W'(psum_lo) + TOT_W'(psum_hi);
    thresh = top_bit ? TOT_W'(NEED_TOP) : TOT_W'(NEED);
    vote   = (total >= thresh);
  end
endmodule

// File: rtl/maj_rst_sync.sv
module maj_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/maj13_voter.sv
module maj13_voter
  import maj_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IN_W-1:0] bits_in,
  output logic            vote_out
);
  logic [N_GRP*CNT_W-1:0]   grp_cnt;
  logic [N_PAIR*PAIR_W-1:0] pair_sum;
  total_t                   total12;
  logic                     vote_comb;
  logic                     rst_sync_n;

  // Layer 1: group decode.
  for (genvar g = 0; g < N_GRP; g++) begin : g_trio
    maj_trio_count u_trio (
      .trio (bits_in[g*GRP_W +: GRP_W]),
      .cnt  (grp_cnt[g*CNT_W +: CNT_W])
    );
  end

  // Layer 2: pairwise add.
  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
    maj_pair_add u_pair (
      .cnt_a (grp_cnt[(2*p)*CNT_W   +: CNT_W]),
      .cnt_b (grp_cnt[(2*p+1)*CNT_W +: CNT_W]),
      .psum  (pair_sum[p*PAIR_W +: PAIR_W])
    );
  end

  // Layer 3: total and threshold picked by the top bit.
  maj_decide u_decide (
    .psum_lo (pair_sum[0      +: PAIR_W]),
    .psum_hi (pair_sum[PAIR_W +: PAIR_W]),
    .top_bit (bits_in[IN_W-1]),
    .total   (total12),
    .vote    (vote_comb)
  );

  if (REG_OUT) begin : g_reg
    logic vote_d;
    logic vote_q;

    maj_rst_sync u_rst_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .rst_sync_n (rst_sync_n)
    );

    always_comb begin
      vote_d = vote_comb;
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        vote_q <= 1'b0;
      end else begin
        vote_q <= vote_d;
      end
    end

    assign vote_out = vote_q;
  end else begin : g_comb
    assign rst_sync_n = rst_n;
    assign vote_out   = vote_comb;
  end
endmodule

// File: rtl/maj13_voter_chk.sv
module maj13_voter_chk
  import maj_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic                     clk,
  input logic                     rst_sync_n,
  input logic [IN_W-1:0]          bits_in,
  input logic [N_GRP*CNT_W-1:0]   grp_cnt,
  input logic [N_PAIR*PAIR_W-1:0] pair_sum,
  input total_t                   total12,
  input logic                     vote_comb,
  input logic                     vote_out
);
  logic primed;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) primed <= 1'b0;
    else             primed <= 1'b1;
  end

  assert_group_count_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (32'(grp_cnt[1:0]) == $countones(bits_in[2:0])) &&
    (32'(grp_cnt[3:2]) == $countones(bits_in[5:3])) &&
    (32'(grp_cnt[5:4]) == $countones(bits_in[8:6])) &&
    (32'(grp_cnt[7:6]) == $countones(bits_in[11:9])));

  assert_pair_sum_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (32'(pair_sum[2:0]) == $countones(bits_in[5:0])) &&
    (32'(pair_sum[5:3]) == $countones(bits_in[11:6])) &&
    (pair_sum[2:0] <= 3'd6) && (pair_sum[5:3] <= 3'd6));

  assert_total_range_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (32'(total12) == $countones(bits_in[11:0])) && (total12 <= 4'd12));

  assert_top_threshold_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    vote_comb == (bits_in[12] ? ($countones(bits_in[11:0]) >= 6)
                              : ($countones(bits_in[11:0]) >= 7)));

  assert_majority_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    vote_comb == ($countones(bits_in) >= 7));

  if (REG_OUT) begin : g_reg_chk
    assert_reg_latency_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      primed |-> (vote_out == $past($countones(bits_in) >= 7)));

    assert_reset_clear_R7: assert property (@(posedge clk)
      !rst_sync_n |-> (vote_out == 1'b0));
  end
endmodule

bind maj13_voter maj13_voter_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bits_in    (bits_in),
  .grp_cnt    (grp_cnt),
  .pair_sum   (pair_sum),
  .total12    (total12),
  .vote_comb  (vote_comb),
  .vote_out   (vote_out)
);

// File: tb/test_maj13_voter.sv
`timescale 1ns/1ps
module test_maj13_voter;
  localparam real HALF = 2.5;

  logic        clk;
  logic        rst_n;
  logic [12:0] bits_in;
  logic        vote_out;

  int checks;
  int errors;
  bit armed;
  bit done;

  typedef struct {
    logic [12:0] word;
    logic        exp;
    string       tag;
  } item_t;

  item_t sb_q[$];

  maj13_voter #(.REG_OUT(1'b1)) i_maj13_voter (
    .clk      (clk),
    .rst_n    (rst_n),
    .bits_in  (bits_in),
    .vote_out (vote_out)
  );

  initial clk = 1'b0;
  always #(HALF) clk = ~clk;

  function automatic int popc(input logic [12:0] w);
    int n = 0;
    for (int i = 0; i < 13; i++) n += int'(w[i]);
    return n;
  endfunction

  function automatic string pick_tag(input logic [12:0] w);
    int low = popc({1'b0, w[11:0]});
    if (w[12] && (low == 6 || low == 5)) return "R4";
    if (!w[12] && (low == 7 || low == 6)) return "R5";
    if (w[5:0] == 6'h3F || w[11:6] == 6'h3F) return "R3";
    if (popc(w) == 3) return "R2";
    return "R1";
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Driver: apply a word at the falling edge and queue its expected result.
  task automatic drive(input logic [12:0] w);
    item_t it;
    @(negedge clk);
    bits_in = w;
    it.word = w;
    it.exp  = (popc(w) >= 7);
    it.tag  = pick_tag(w);
    sb_q.push_back(it);
  endtask

  // Monitor: one cycle of latency, sampled 1 ns after the capturing edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (armed && sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (vote_out !== it.exp) begin
          errors++;
          $display("FAIL %s word=%h actual=%b expected=%b",
                   it.tag, it.word, vote_out, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks  = 0;
    errors  = 0;
    armed   = 1'b0;
    done    = 1'b0;
    rst_n   = 1'b1;
    bits_in = 13'h1FFF;
    #1 rst_n = 1'b0;

    // R7: output cleared during reset even with an all-ones input.
    repeat (3) @(posedge clk);
    #1 check("R7 reset state", vote_out, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1 check("R7 held after release", vote_out, 1'b0);
    @(negedge clk);
    bits_in = 13'h0000;
    repeat (3) @(posedge clk);

    // R6: the output keeps its old value until the capturing edge.
    @(negedge clk);
    bits_in = 13'h1FFF;
    #2 check("R6 before edge", vote_out, 1'b0);
    @(posedge clk);
    #1 check("R6 after edge", vote_out, 1'b1);

    // Exhaustive sweep through the scoreboard (R1..R5).
    armed = 1'b1;
    for (int v = 0; v < 8192; v++) drive(13'(v));
    repeat (3) @(posedge clk);
    armed = 1'b0;
    if (sb_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R1 scoreboard left=%0d expected=0", sb_q.size());
    end

    // Named corners: top bit lowering the threshold (R4), exact seven (R5).
    armed = 1'b1;
    drive(13'h103F);
    drive(13'h003F);
    drive(13'h007F);
    drive(13'h1000);
    drive(13'h0FFF);
    repeat (3) @(posedge clk);
    armed = 1'b0;

    // R7: reset in mid-stream clears a result of 1 at once.
    @(negedge clk);
    bits_in = 13'h1FFF;
    @(posedge clk);
    #1 check("R7 pre-reset one", vote_out, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R7 async clear", vote_out, 1'b0);
    @(posedge clk);
    #1 check("R7 clear holds", vote_out, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1 check("R7 first edge after release", vote_out, 1'b0);
    repeat (3) @(posedge clk);
    #1 check("R6 resumes", vote_out, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule